// File: doc/BRIEF.md
# Serial Configuration Register Bank with Burst Writes

This block is a write-only serial slave. It takes a three-wire link made up of a serial clock, a serial data line and an active-low frame select, and uses it to program four 12-bit control registers for an imaging front end. The three link inputs are asynchronous to the system clock. They pass through a synchronizer, and their edges are detected in the system clock domain.

A frame opens when the select line falls. The bits that follow are taken on serial-clock rising edges, least significant bit first. The first three bits form a start address. Every complete 12-bit word after that is staged for the current address, and the address then steps by one. The staged words stay invisible at the outputs until the select line rises, and at that point they are all committed together.

Writing the reset bit in the operation register restores every register to its default value. For a set number of clock cycles after reset, the link is ignored while the front end finishes its initialisation.

Top module: `ser_cfg_regs`

## Requirements
- R1: A frame is the span with `ser_sel_n` low. Data bits are taken on `ser_clk` rising edges, LSB first: three address bits, then 12-bit words.
- R2: In a burst, word k of a frame goes to address (start + k) modulo 8. Words aimed at addresses 4 to 7 are discarded.
- R3: Staged words have no effect on any output until `ser_sel_n` rises. At that rise, all words staged in the frame are committed together.
- R4: A word left incomplete when `ser_sel_n` rises is discarded. A frame that ends inside the address bits changes nothing.
- R5: After reset, `init_done` is 0, `clamp_lvl` is 128, and every other field output is 0.
- R6: Committing an operation word (address 0) with bit 0 set returns every register to its R5 default value. This holds even when other words were committed in the same frame.
- R7: Frames sent during the first INIT_CYCLES clocks after reset are ignored. `init_done` then rises and stays high.
- R8: The register fields are laid out as follows.
  - Address 0: bits [2:1] drive `pwr_mode` and bit 3 drives `clamp_off`.
  - Address 1: bits 0 to 6 drive `pol_sample`, `pol_dclk`, `pol_clamp`, `pol_blank`, `out_hiz`, `latch_open` and `gray_out`, in that order.
  - Address 2: bits [7:0] drive `clamp_lvl`.
  - Address 3: bits [9:0] drive `vga_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_din | input | 1 | Serial data, LSB first |
| ser_sel_n | input | 1 | Frame select, active low; its rising edge commits |
| init_done | output | 1 | High once the power-on lockout has elapsed |
| pwr_mode | output | 2 | Power mode field |
| clamp_off | output | 1 | Black clamp disable |
| pol_sample | output | 1 | Sampling clock polarity |
| pol_dclk | output | 1 | Output latch clock polarity |
| pol_clamp | output | 1 | Clamp pulse polarity |
| pol_blank | output | 1 | Blanking pulse polarity |
| out_hiz | output | 1 | Data output high-impedance request |
| latch_open | output | 1 | Output latch transparent |
| gray_out | output | 1 | Gray coded output select |
| clamp_lvl | output | 8 | Black clamp level |
| vga_code | output | 10 | Gain code |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A burst that starts at address 3 and runs past address 7. A design with a saturating address would pile words onto one register, and one that stores into addresses 4 to 7 would alias them onto real registers.
- Checks of the outputs taken in the middle of a frame. These catch a design that writes words straight through instead of holding them until the commit.
- Frames with trailing stray bits, and frames cut short inside the address bits. These catch commits of half-shifted words.
- A soft reset mixed into a burst. This shows whether the other words in that burst wrongly survive the reset.
- A frame sent during the lockout. This exposes a design that accepts writes before initialisation ends.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  localparam int ADDR_W   = 3;
  localparam int WORD_W   = 12;
  localparam int NUM_REGS = 4;
  localparam int IDX_W    = $clog2(WORD_W);
  localparam int SRST_BIT = 0;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t reg_default(input int idx);
    return (idx == 2) ? word_t'(128) : '0;
  endfunction

  function automatic word_t reg_mask(input int idx);
    case (idx)
      0:       return word_t'(12'h00F);
      1:       return word_t'(12'h07F);
      2:       return word_t'(12'h0FF);
      default: return word_t'(12'h3FF);
    endcase
  endfunction
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_in,
  input  logic din_in,
  input  logic sel_n_in,
  output logic clk_rise,
  output logic sel_rise,
  output logic sel_fall,
  output logic sel_low,
  output logic din_sync
);
  // vector order: {sel_n, din, clk}
  localparam logic [2:0] IDLE_VAL = 3'b100;

  logic [STAGES-1:0][2:0] stage_q;
  logic [1:0]             prev_q;   // {sel_n, clk}
  logic [2:0]             last;

  assign last = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{IDLE_VAL}};
      prev_q  <= 2'b10;
    end else begin
      stage_q[0] <= {sel_n_in, din_in, clk_in};
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= {last[2], last[0]};
    end
  end

  assign clk_rise = last[0] & ~prev_q[0];
  assign sel_rise = last[2] & ~prev_q[1];
  assign sel_fall = ~last[2] & prev_q[1];
  assign sel_low  = ~last[2];
  assign din_sync = last[1];
endmodule

// File: rtl/ser_cfg_lockout.sv
module ser_cfg_lockout #(
  parameter int INIT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  generate
    if (INIT_CYCLES == 0) begin : g_none
      assign done = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(INIT_CYCLES + 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          done_q, done_d;

      always_comb begin
        cnt_d  = cnt_q;
        done_d = done_q;
        if (!done_q) begin
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == CW'(INIT_CYCLES - 1)) done_d = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          done_q <= 1'b0;
        end else begin
          cnt_q  <= cnt_d;
          done_q <= done_d;
        end
      end

      assign done = done_q;
    end
  endgenerate
endmodule

// File: rtl/ser_cfg_deser.sv
module ser_cfg_deser
  import ser_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_stb,
  input  logic              frame_open,
  input  logic              frame_live,
  input  logic              din,
  output logic              word_vld,
  output logic [ADDR_W-1:0] word_addr,
  output word_t             word_data,
  output logic [ADDR_W-1:0] tgt_addr
);
  phase_t            phase_q, phase_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  word_t             acc_q, acc_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic              wv_q, wv_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  word_t             wd_q, wd_d;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    tgt_d   = tgt_q;
    wv_d    = 1'b0;
    wa_d    = wa_q;
    wd_d    = wd_q;
    if (frame_open) begin
      phase_d = PH_ADDR;
      idx_d   = '0;
      acc_d   = '0;
    end else if (!frame_live) begin
      phase_d = PH_IDLE;
    end else if (bit_stb && en) begin
      case (phase_q)
        PH_ADDR: begin
          acc_d[idx_q] = din;
          if (idx_q == IDX_W'(ADDR_W - 1)) begin
            tgt_d   = acc_d[ADDR_W-1:0];
            phase_d = PH_DATA;
            idx_d   = '0;
            acc_d   = '0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
        PH_DATA: begin
          acc_d[idx_q] = din;
          if (idx_q == IDX_W'(WORD_W - 1)) begin
            wv_d  = 1'b1;
            wa_d  = tgt_q;
            wd_d  = acc_d;
            tgt_d = tgt_q + ADDR_W'(1);
            idx_d = '0;
            acc_d = '0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
      tgt_q   <= '0;
      wv_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      acc_q   <= acc_d;
      tgt_q   <= tgt_d;
      wv_q    <= wv_d;
      wa_q    <= wa_d;
      wd_q    <= wd_d;
    end
  end

  assign word_vld  = wv_q;
  assign word_addr = wa_q;
  assign word_data = wd_q;
  assign tgt_addr  = tgt_q;
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
  import ser_cfg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         word_vld,
  input  logic [ADDR_W-1:0]            word_addr,
  input  word_t                        word_data,
  input  logic                         commit,
  input  logic                         clear,
  output logic [NUM_REGS-1:0][WORD_W-1:0] live
);
  logic [NUM_REGS-1:0][WORD_W-1:0] shadow_q, shadow_d;
  logic [NUM_REGS-1:0]             pend_q, pend_d;
  logic [NUM_REGS-1:0][WORD_W-1:0] live_q, live_d;
  logic                            soft_rst;

  assign soft_rst = pend_q[0] & shadow_q[0][SRST_BIT];

  always_comb begin
    shadow_d = shadow_q;
    pend_d   = pend_q;
    live_d   = live_q;
    if (commit) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (soft_rst)       live_d[i] = reg_default(i);
        else if (pend_q[i]) live_d[i] = shadow_q[i];
      end
      pend_d = '0;
    end else if (clear) begin
      pend_d = '0;
    end
    if (word_vld) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (word_addr == ADDR_W'(i)) begin
          shadow_d[i] = word_data & reg_mask(i);
          pend_d[i]   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= '0;
      for (int i = 0; i < NUM_REGS; i++) live_q[i] <= reg_default(i);
    end else begin
      shadow_q <= shadow_d;
      pend_q   <= pend_d;
      live_q   <= live_d;
    end
  end

  assign live = live_q;
endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INIT_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_din,
  input  logic       ser_sel_n,
  output logic       init_done,
  output logic [1:0] pwr_mode,
  output logic       clamp_off,
  output logic       pol_sample,
  output logic       pol_dclk,
  output logic       pol_clamp,
  output logic       pol_blank,
  output logic       out_hiz,
  output logic       latch_open,
  output logic       gray_out,
  output logic [7:0] clamp_lvl,
  output logic [9:0] vga_code
);
  logic                            clk_rise, sel_rise, sel_fall, sel_low, din_sync;
  logic                            word_vld;
  logic [ADDR_W-1:0]               word_addr, tgt_addr;
  word_t                           word_data;
  logic [NUM_REGS-1:0][WORD_W-1:0] live;

  ser_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clk_in(ser_clk), .din_in(ser_din), .sel_n_in(ser_sel_n),
    .clk_rise(clk_rise), .sel_rise(sel_rise), .sel_fall(sel_fall), .sel_low(sel_low),
    .din_sync(din_sync)
  );

  ser_cfg_lockout #(.INIT_CYCLES(INIT_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .done(init_done)
  );

  ser_cfg_deser u_deser (
    .clk(clk), .rst_n(rst_n), .en(init_done), .bit_stb(clk_rise), .frame_open(sel_fall),
    .frame_live(sel_low), .din(din_sync), .word_vld(word_vld), .word_addr(word_addr),
    .word_data(word_data), .tgt_addr(tgt_addr)
  );

  ser_cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_addr(word_addr),
    .word_data(word_data), .commit(sel_rise), .clear(sel_fall), .live(live)
  );

  assign pwr_mode   = live[0][2:1];
  assign clamp_off  = live[0][3];
  assign pol_sample = live[1][0];
  assign pol_dclk   = live[1][1];
  assign pol_clamp  = live[1][2];
  assign pol_blank  = live[1][3];
  assign out_hiz    = live[1][4];
  assign latch_open = live[1][5];
  assign gray_out   = live[1][6];
  assign clamp_lvl  = live[2][7:0];
  assign vga_code   = live[3][9:0];

  logic unused_bits;
  assign unused_bits = ^{live[0][11:4], live[0][0], live[1][11:7], live[2][11:8], live[3][11:10]};
endmodule

// File: rtl/ser_cfg_regs_chk.sv
module ser_cfg_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        commit,
  input logic        word_vld,
  input logic [2:0]  word_addr,
  input logic [2:0]  tgt_addr,
  input logic        init_done,
  input logic [27:0] outs
);
  // R3: outputs only move in the cycle after a commit strobe
  p_live_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(outs));

  // R2: after a completed word the target address has stepped by one (mod 8)
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> tgt_addr == word_addr + 3'd1);

  // R7: no word is accepted while the lockout runs
  p_locked_no_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !word_vld);

  // R7: init_done never drops once set
  p_init_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R5: default field values right after reset release
  p_reset_vals_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> outs == 28'h0020000);
endmodule

bind ser_cfg_regs ser_cfg_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit(sel_rise), .word_vld(word_vld),
  .word_addr(word_addr), .tgt_addr(tgt_addr), .init_done(init_done),
  .outs({pwr_mode, clamp_off, pol_sample, pol_dclk, pol_clamp, pol_blank,
         out_hiz, latch_open, gray_out, clamp_lvl, vga_code})
);

// File: tb/ser_cfg_regs_test.sv
`timescale 1ns/1ps
module ser_cfg_regs_test;
  localparam int LOCK = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_sel_n = 1'b1;
  logic init_done, clamp_off, pol_sample, pol_dclk, pol_clamp, pol_blank;
  logic out_hiz, latch_open, gray_out;
  logic [1:0] pwr_mode;
  logic [7:0] clamp_lvl;
  logic [9:0] vga_code;

  int checks = 0;
  int errors = 0;

  logic [11:0] mreg [4];
  logic [11:0] msh  [4];
  logic [3:0]  mpend;

  always #2.5 clk = ~clk;

  ser_cfg_regs #(.SYNC_STAGES(2), .INIT_CYCLES(LOCK)) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din), .ser_sel_n(ser_sel_n),
    .init_done(init_done), .pwr_mode(pwr_mode), .clamp_off(clamp_off),
    .pol_sample(pol_sample), .pol_dclk(pol_dclk), .pol_clamp(pol_clamp),
    .pol_blank(pol_blank), .out_hiz(out_hiz), .latch_open(latch_open),
    .gray_out(gray_out), .clamp_lvl(clamp_lvl), .vga_code(vga_code)
  );

  function automatic logic [11:0] fmask(input int i);
    case (i)
      0: return 12'h00F;
      1: return 12'h07F;
      2: return 12'h0FF;
      default: return 12'h3FF;
    endcase
  endfunction

  function automatic logic [27:0] got_vec();
    return {pwr_mode, clamp_off, pol_sample, pol_dclk, pol_clamp, pol_blank,
            out_hiz, latch_open, gray_out, clamp_lvl, vga_code};
  endfunction

  function automatic logic [27:0] exp_vec();
    return {mreg[0][2:1], mreg[0][3], mreg[1][0], mreg[1][1], mreg[1][2], mreg[1][3],
            mreg[1][4], mreg[1][5], mreg[1][6], mreg[2][7:0], mreg[3][9:0]};
  endfunction

  task automatic mdl_defaults();
    for (int i = 0; i < 4; i++) mreg[i] = (i == 2) ? 12'd128 : 12'd0;
    mpend = '0;
  endtask

  task automatic mdl_word(input logic [2:0] a, input logic [11:0] d);
    if (a < 3'd4) begin
      msh[a[1:0]]   = d & fmask(int'(a));
      mpend[a[1:0]] = 1'b1;
    end
  endtask

  task automatic mdl_commit();
    if (mpend[0] && msh[0][0]) mdl_defaults();
    else for (int i = 0; i < 4; i++) if (mpend[i]) mreg[i] = msh[i];
    mpend = '0;
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    ser_din = b;
    wclk(4);
    ser_clk = 1'b1;
    wclk(4);
    ser_clk = 1'b0;
  endtask

  task automatic shift(input logic [11:0] v, input int n);
    for (int i = 0; i < n; i++) sbit(v[i]);
  endtask

  task automatic open_frame(input logic [2:0] a);
    ser_sel_n = 1'b0;
    wclk(4);
    shift({9'd0, a}, 3);
  endtask

  task automatic close_frame();
    wclk(4);
    ser_sel_n = 1'b1;
    wclk(10);
  endtask

  task automatic chk(input string req, input logic [27:0] g, input logic [27:0] e);
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, g, e);
    end
  endtask

  task automatic burst(input logic [2:0] a, input int n, input int extra, input logic [11:0] seedw);
    logic [11:0] w;
    open_frame(a);
    for (int k = 0; k < n; k++) begin
      w = seedw ^ 12'(k * 12'h1A5);
      if (k == 0 && a == 3'd0) w[0] = 1'b0;
      shift(w, 12);
      mdl_word(a + 3'(k), w);
    end
    if (extra > 0) shift(12'hFFF, extra);
    chk("R3 mid-frame hold", got_vec(), exp_vec());
    close_frame();
    mdl_commit();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [11:0] w;
    int n, ex;
    logic [2:0] a;
    void'($urandom(32'h5EED_0042));
    mdl_defaults();
    wclk(4);
    rst_n = 1'b1;
    wclk(1);
    // R5 reset state
    chk("R5 defaults", got_vec(), exp_vec());
    chk("R5 init_done low", {27'd0, init_done}, 28'd0);

    // R7 frame during lockout is ignored
    open_frame(3'd3);
    shift(12'h2AB, 12);
    close_frame();
    chk("R7 locked write ignored", got_vec(), exp_vec());
    while (!init_done) wclk(1);
    wclk(20);
    chk("R7 init_done high", {27'd0, init_done}, 28'd1);

    // R1 R3 single write with mid-frame hold
    open_frame(3'd3);
    shift(12'h3FF, 12);
    mdl_word(3'd3, 12'h3FF);
    chk("R3 not yet committed", got_vec(), exp_vec());
    close_frame();
    mdl_commit();
    chk("R1 gain write", got_vec(), exp_vec());

    // R8 walk each control bit and op fields
    for (int k = 0; k < 7; k++) begin
      open_frame(3'd1);
      shift(12'(1 << k), 12);
      mdl_word(3'd1, 12'(1 << k));
      close_frame();
      mdl_commit();
      chk("R8 control bit map", got_vec(), exp_vec());
    end
    open_frame(3'd0);
    shift(12'h00C, 12);
    mdl_word(3'd0, 12'h00C);
    close_frame();
    mdl_commit();
    chk("R8 operation fields", got_vec(), exp_vec());

    // R2 burst wrapping past address 7
    burst(3'd3, 6, 0, 12'h5C3);
    chk("R2 wrap burst", got_vec(), exp_vec());
    burst(3'd1, 3, 0, 12'hA96);
    chk("R2 burst 1..3", got_vec(), exp_vec());

    // R4 partial word discarded, short frame changes nothing
    burst(3'd2, 1, 7, 12'h055);
    chk("R4 partial tail", got_vec(), exp_vec());
    ser_sel_n = 1'b0;
    wclk(4);
    shift(12'h002, 2);
    close_frame();
    chk("R4 address-only frame", got_vec(), exp_vec());

    // R6 soft reset within a burst
    open_frame(3'd0);
    shift(12'h007, 12); mdl_word(3'd0, 12'h007);
    shift(12'h07F, 12); mdl_word(3'd1, 12'h07F);
    shift(12'h0F0, 12); mdl_word(3'd2, 12'h0F0);
    close_frame();
    mdl_commit();
    chk("R6 soft reset", got_vec(), exp_vec());

    // R1 R2 random frames
    for (int t = 0; t < 20; t++) begin
      a  = 3'($urandom_range(0, 7));
      n  = $urandom_range(1, 5);
      ex = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 11) : 0;
      w  = 12'($urandom);
      burst(a, n, ex, w);
      chk("R1 R2 random burst", got_vec(), exp_vec());
    end
    chk("R7 init_done sticky", {27'd0, init_done}, 28'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule